// File: doc/BRIEF.md
# Vectored Interrupt Controller with Non-Maskable Lines

The block gathers level-sensitive interrupt lines from peripherals and presents them to a processor core as one interrupt request wire plus an 8-bit vector bus. Each ordinary line sets a bit in a raw pending word. That word is ANDed with a software-written enable mask to form a masked pending word. When exactly one masked bit is active, the vector names that source. When two or more are active, the block gives out one shared vector, and the interrupt handler reads the masked pending word to choose which source to serve first.

The two highest lines do not enter the pending word. They feed a separate non-maskable status word and a non-maskable request output, and the enable mask has no effect on them. A plain 32-bit register port, with a byte address and a combinational read, gives software the mask and all status words.

Every state element is registered. A change on an input line or a write to the mask shows on the outputs one clock later.

Top module: `intc_vectored`

## Requirements
- R1: The word index is the byte address shifted right by 2. Word 0 reads the enable mask, word 1 the raw pending word, word 2 the masked pending word and word 3 the non-maskable status word. Word 4 is reserved, and it and words 5 to 7 read as zero. Read data is valid in the same cycle as the address and is zero while the port is not selected.
- R2: A write with select and write high to word 0 loads the mask at the next rising edge. A write to any other word changes no register and no output.
- R3: In every cycle the masked pending word equals the raw pending word ANDed with the mask. A mask write and a line change are both reflected one cycle later.
- R4: When the masked pending word is zero, the vector is 0x00.
- R5: When exactly one masked bit i is set, the vector is 0x31 + i. For line n this is 0x30 + n.
- R6: When two or more masked bits are set, the vector is 0x30.
- R7: The interrupt request output is high exactly when the vector is nonzero.
- R8: Lines 30 and 31 never set a pending bit. Each one drives bit 30 or bit 31 of the non-maskable status word, following its level.
- R9: The non-maskable request output is high whenever any non-maskable status bit is set, whatever the mask holds.
- R10: Line n, for n from 1 to 29, drives raw pending bit n-1 and follows its level, so dropping the line clears the bit. Line 0 is ignored, and pending bits 29 to 31 are always zero.
- R11: Reset clears the mask, all status words, the vector and both request outputs. After reset the outputs change one rising edge after the line or mask change that causes them, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_lines_i | input | 32 | Level-sensitive interrupt lines 0 to 31 |
| bus_sel_i | input | 1 | Register port select |
| bus_wr_i | input | 1 | Write strobe, valid with select |
| bus_addr_i | input | 5 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data |
| irq_o | output | 1 | Maskable interrupt request |
| vector_o | output | 8 | Interrupt vector |
| nmi_o | output | 1 | Non-maskable interrupt request |

## Verification
The assertions check on every cycle that the masked word is the AND of pending and mask, that the vector agrees with the population of the masked word (zero, source-specific or shared), that the request outputs agree with the vector and the non-maskable word, that pending and non-maskable bits follow the lines of the previous cycle, and that the mask holds unless word 0 is written. Only the bench scenarios show the absolute encodings seen at the ports: the exact vector value for particular lines, the register offsets and the zero returned by the reserved and unmapped words. They also show that writes to read-only words leave the vector unchanged, and that an output stays at its old value until the edge after a change.

// File: rtl/intc_pkg.sv
package intc_pkg;

    // Register word width and vector bus width.
    localparam int unsigned WORD_W = 32;
    localparam int unsigned VEC_W  = 8;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [VEC_W-1:0]  vec_t;

    // Word indices of the register port. The handler relies on these values.
    localparam logic [2:0] IDX_MASK   = 3'd0;
    localparam logic [2:0] IDX_PEND   = 3'd1;
    localparam logic [2:0] IDX_MASKED = 3'd2;
    localparam logic [2:0] IDX_NMI    = 3'd3;
    localparam logic [2:0] IDX_RSVD   = 3'd4;

    // Complete registered state of the controller.
    typedef struct packed {
        word_t mask;
        word_t pend;
        word_t masked;
        word_t nmi;
        vec_t  vec;
        logic  irq;
        logic  nmi_req;
    } intc_state_t;

endpackage

// File: rtl/intc_line_map.sv
module intc_line_map
    import intc_pkg::*;
#(
    parameter int unsigned NUM_LINES = 32,
    parameter int unsigned NMI_FIRST = 30
) (
    input  logic [NUM_LINES-1:0] lines_i,
    output word_t                pend_o,
    output word_t                nmi_o
);

    // Ordinary line n feeds pending bit n-1; line 0 has no bit.
    // Lines from NMI_FIRST upward land on their own bit of the NMI word.
    for (genvar b = 0; b < WORD_W; b++) begin : g_bit
        if (b + 1 < NMI_FIRST && b + 1 < NUM_LINES) begin : g_pend
            assign pend_o[b] = lines_i[b+1];
        end else begin : g_pend_zero
            assign pend_o[b] = 1'b0;
        end

        if (b >= NMI_FIRST && b < NUM_LINES) begin : g_nmi
            assign nmi_o[b] = lines_i[b];
        end else begin : g_nmi_zero
            assign nmi_o[b] = 1'b0;
        end
    end

endmodule

// File: rtl/intc_vec_enc.sv
module intc_vec_enc
    import intc_pkg::*;
#(
    parameter logic [VEC_W-1:0] SHARED_VEC = 8'h30
) (
    input  word_t masked_i,
    output vec_t  vec_o
);

    localparam int unsigned IDX_W = $clog2(WORD_W);

    logic             any_set;
    logic             single_set;
    logic [IDX_W-1:0] low_idx;

    // Lowest set bit; its value only matters when exactly one bit is set.
    always_comb begin
        low_idx = '0;
        for (int b = WORD_W - 1; b >= 0; b--) begin
            if (masked_i[b]) begin
                low_idx = IDX_W'(b);
            end
        end
    end

    assign any_set    = |masked_i;
    assign single_set = any_set && ((masked_i & (masked_i - word_t'(1))) == '0);

    always_comb begin
        if (!any_set) begin
            vec_o = '0;
        end else if (single_set) begin
            vec_o = SHARED_VEC + vec_t'(1) + vec_t'(low_idx);
        end else begin
            vec_o = SHARED_VEC;
        end
    end

endmodule

// File: rtl/intc_readmux.sv
module intc_readmux
    import intc_pkg::*;
#(
    parameter int unsigned ADDR_W = 5
) (
    input  logic              sel_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  intc_state_t       st_i,
    output word_t             rdata_o
);

    localparam int unsigned WIDX_W = ADDR_W - 2;

    logic [WIDX_W-1:0] widx;

    assign widx = addr_i[ADDR_W-1:2];

    always_comb begin
        rdata_o = '0;
        if (sel_i) begin
            if (widx == WIDX_W'(IDX_MASK)) begin
                rdata_o = st_i.mask;
            end else if (widx == WIDX_W'(IDX_PEND)) begin
                rdata_o = st_i.pend;
            end else if (widx == WIDX_W'(IDX_MASKED)) begin
                rdata_o = st_i.masked;
            end else if (widx == WIDX_W'(IDX_NMI)) begin
                rdata_o = st_i.nmi;
            end else begin
                // Reserved word and unmapped words read as zero.
                rdata_o = '0;
            end
        end
    end

endmodule

// File: rtl/intc_vectored.sv
module intc_vectored
    import intc_pkg::*;
#(
    parameter int unsigned       NUM_LINES  = 32,
    parameter int unsigned       NMI_FIRST  = 30,
    parameter int unsigned       ADDR_W     = 5,
    parameter logic [VEC_W-1:0]  SHARED_VEC = 8'h30
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic [NUM_LINES-1:0] irq_lines_i,
    input  logic                 bus_sel_i,
    input  logic                 bus_wr_i,
    input  logic [ADDR_W-1:0]    bus_addr_i,
    input  logic [WORD_W-1:0]    bus_wdata_i,
    output logic [WORD_W-1:0]    bus_rdata_o,
    output logic                 irq_o,
    output logic [VEC_W-1:0]     vector_o,
    output logic                 nmi_o
);

    localparam int unsigned WIDX_W   = ADDR_W - 2;
    localparam int unsigned IDX_W    = $clog2(WORD_W);
    localparam int unsigned NUM_NORM = NMI_FIRST - 1;

    intc_state_t st_d, st_q;

    word_t pend_next;
    word_t nmi_next;
    word_t masked_next;
    vec_t  vec_next;
    logic  mask_wr;

    assign mask_wr = bus_sel_i && bus_wr_i
                     && (bus_addr_i[ADDR_W-1:2] == WIDX_W'(IDX_MASK));

    intc_line_map #(
        .NUM_LINES (NUM_LINES),
        .NMI_FIRST (NMI_FIRST)
    ) u_line_map (
        .lines_i (irq_lines_i),
        .pend_o  (pend_next),
        .nmi_o   (nmi_next)
    );

    intc_vec_enc #(
        .SHARED_VEC (SHARED_VEC)
    ) u_vec_enc (
        .masked_i (masked_next),
        .vec_o    (vec_next)
    );

    // Next-state process: every field of the state computed in one place.
    always_comb begin
        st_d         = st_q;
        st_d.mask    = mask_wr ? bus_wdata_i : st_q.mask;
        st_d.pend    = pend_next;
        st_d.nmi     = nmi_next;
        masked_next  = st_d.pend & st_d.mask;
        st_d.masked  = masked_next;
        st_d.vec     = vec_next;
        st_d.irq     = (vec_next != '0);
        st_d.nmi_req = (nmi_next != '0);
    end

    // State register.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    intc_readmux #(
        .ADDR_W (ADDR_W)
    ) u_readmux (
        .sel_i   (bus_sel_i),
        .addr_i  (bus_addr_i),
        .st_i    (st_q),
        .rdata_o (bus_rdata_o)
    );

    assign irq_o    = st_q.irq;
    assign vector_o = st_q.vec;
    assign nmi_o    = st_q.nmi_req;

    // ---------------- assertions ----------------
    logic             chk_armed_q;
    logic [IDX_W-1:0] chk_idx;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            chk_armed_q <= 1'b0;
        end else begin
            chk_armed_q <= 1'b1;
        end
    end

    assign chk_idx = IDX_W'(vector_o - SHARED_VEC - vec_t'(1));

    p_masked_and_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.masked == (st_q.pend & st_q.mask));

    p_vec_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.masked == '0) |-> (vector_o == '0));

    p_vec_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot(st_q.masked) |-> ((vector_o > SHARED_VEC) && st_q.masked[chk_idx]));

    p_vec_shared_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($countones(st_q.masked) > 1) |-> (vector_o == SHARED_VEC));

    p_irq_match_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o == (vector_o != '0));

    p_nmi_follow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        chk_armed_q |-> (st_q.nmi[NUM_LINES-1:NMI_FIRST] == $past(irq_lines_i[NUM_LINES-1:NMI_FIRST])));

    p_nmi_out_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        nmi_o == (st_q.nmi != '0));

    p_pend_follow_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        chk_armed_q |-> (st_q.pend[NUM_NORM-1:0] == $past(irq_lines_i[NMI_FIRST-1:1])));

    p_pend_top_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.pend[WORD_W-1:NUM_NORM] == '0);

    p_mask_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(bus_sel_i && bus_wr_i && (bus_addr_i[ADDR_W-1:2] == WIDX_W'(IDX_MASK)))
        |=> $stable(st_q.mask));

endmodule

// File: tb/intc_vectored_tb.sv
module intc_vectored_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lines = '0;
    logic        sel = 1'b0;
    logic        wr = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;
    logic [7:0]  vec;
    logic        nmi;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    intc_vectored dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .irq_lines_i (lines),
        .bus_sel_i   (sel),
        .bus_wr_i    (wr),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .irq_o       (irq),
        .vector_o    (vec),
        .nmi_o       (nmi)
    );

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", what, act, exp);
        end
    endtask

    // Drive lines at a falling edge, let one rising edge pass, return at the next falling edge.
    task automatic set_lines(input logic [31:0] v);
        lines = v;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic reg_write(input logic [4:0] a, input logic [31:0] d);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        sel = 1'b0; wr = 1'b0; wdata = '0;
    endtask

    task automatic reg_read(input logic [4:0] a, output logic [31:0] d);
        sel = 1'b1; wr = 1'b0; addr = a;
        #1;
        d = rdata;
        sel = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R11 vector after reset", 32'(vec), 32'h0);
        check("R11 irq after reset", 32'(irq), 32'h0);
        check("R11 nmi after reset", 32'(nmi), 32'h0);
        for (int w = 0; w < 4; w++) begin
            reg_read(5'(w * 4), d);
            check($sformatf("R11 word %0d after reset", w), d, 32'h0);
        end
    endtask

    task automatic t_single();
        logic [31:0] d;
        reg_write(5'h00, 32'hFFFF_FFFF);
        reg_read(5'h00, d);
        check("R1 mask readback", d, 32'hFFFF_FFFF);
        set_lines(32'h1 << 5);
        check("R5 line 5 vector", 32'(vec), 32'h35);
        check("R7 irq with line 5", 32'(irq), 32'h1);
        reg_read(5'h04, d);
        check("R10 line 5 pending bit 4", d, 32'h10);
        set_lines(32'h1 << 1);
        check("R5 line 1 vector", 32'(vec), 32'h31);
        set_lines(32'h1 << 29);
        check("R5 line 29 vector", 32'(vec), 32'h4D);
        reg_read(5'h04, d);
        check("R10 line 29 pending bit 28", d, 32'h1000_0000);
    endtask

    task automatic t_multi();
        set_lines((32'h1 << 3) | (32'h1 << 7));
        check("R6 two sources shared vector", 32'(vec), 32'h30);
        check("R7 irq with two sources", 32'(irq), 32'h1);
    endtask

    task automatic t_mask();
        logic [31:0] d;
        reg_write(5'h00, 32'h0000_0004);
        check("R3 masked to one source vector", 32'(vec), 32'h33);
        reg_read(5'h08, d);
        check("R3 masked word", d, 32'h0000_0004);
        reg_read(5'h04, d);
        check("R3 raw pending unaffected by mask", d, 32'h0000_0044);
        reg_write(5'h00, 32'h0);
        check("R4 no masked source vector", 32'(vec), 32'h0);
        check("R7 irq low with zero vector", 32'(irq), 32'h0);
    endtask

    task automatic t_readonly();
        logic [31:0] d;
        reg_write(5'h00, 32'h0000_0040);
        check("R2 baseline vector", 32'(vec), 32'h37);
        for (int w = 1; w < 8; w++) begin
            reg_write(5'(w * 4), 32'hFFFF_FFFF);
            check($sformatf("R2 vector after write to word %0d", w), 32'(vec), 32'h37);
        end
        reg_read(5'h00, d);
        check("R2 mask kept", d, 32'h0000_0040);
        reg_read(5'h10, d);
        check("R1 reserved word reads zero", d, 32'h0);
        reg_read(5'h14, d);
        check("R1 unmapped word reads zero", d, 32'h0);
        sel = 1'b0; addr = 5'h04; #1;
        check("R1 read data zero when not selected", rdata, 32'h0);
    endtask

    task automatic t_nmi();
        logic [31:0] d;
        reg_write(5'h00, 32'h0);
        set_lines(32'h1 << 30);
        check("R9 nmi with line 30 and zero mask", 32'(nmi), 32'h1);
        check("R8 line 30 gives no vector", 32'(vec), 32'h0);
        reg_read(5'h0C, d);
        check("R8 nmi word bit 30", d, 32'h4000_0000);
        reg_read(5'h04, d);
        check("R8 pending untouched by line 30", d, 32'h0);
        reg_write(5'h00, 32'hFFFF_FFFF);
        set_lines(32'h1 << 31);
        reg_read(5'h0C, d);
        check("R8 nmi word bit 31", d, 32'h8000_0000);
        check("R8 line 31 gives no irq", 32'(irq), 32'h0);
        set_lines(32'h0);
        check("R9 nmi drops with lines", 32'(nmi), 32'h0);
    endtask

    task automatic t_follow();
        logic [31:0] d;
        set_lines(32'h1);
        reg_read(5'h04, d);
        check("R10 line 0 ignored", d, 32'h0);
        check("R10 line 0 gives no vector", 32'(vec), 32'h0);
        set_lines(32'h1 << 9);
        check("R10 line 9 vector", 32'(vec), 32'h39);
        set_lines(32'h0);
        reg_read(5'h04, d);
        check("R10 pending cleared on release", d, 32'h0);
        check("R10 vector cleared on release", 32'(vec), 32'h0);
    endtask

    task automatic t_latency();
        lines = 32'h1 << 12;
        #2;
        check("R11 vector unchanged before edge", 32'(vec), 32'h0);
        @(posedge clk);
        @(negedge clk);
        check("R11 vector after one edge", 32'(vec), 32'h3C);
        set_lines(32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_multi();
        t_mask();
        t_readonly();
        t_nmi();
        t_follow();
        t_latency();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule